// File: doc/BRIEF.md
# Thread-Partitioned Non-Blocking Data Cache

This block is the data cache of a fine-grained multithreaded pipeline. Every hardware thread owns a private slice of a direct-mapped, write-allocate, write-back store. The thread number supplies the upper bits of the set index, so one thread can never displace another thread's lines. Each access carries a thread number, a byte address, a load/store flag, four byte enables and a 32-bit word. The access is captured at one clock edge. The tag is compared and the array is updated or read at the next edge, when the response is produced.

A miss never stalls the pipeline. The response carries a replay flag, the thread is marked pending, and the cache queues commands for a 128-bit memory port. If the victim line is dirty, a two-beat writeback of it is queued first, followed by a read of the missing block. The block is refilled by two beats tagged with the thread number. A pending thread replays every access until its refill lands. Other threads keep hitting and missing independently, so at most one miss per thread is outstanding.

Top module: `pt_dcache`

## Requirements
- R1: After reset, no response and no memory command is presented, and every line is invalid, so the first access of any thread misses.
- R2: Exactly one of resp_hit and resp_replay is set with each response. A load miss sets resp_replay and queues a read command (mem_req_we=0) for the 32-byte-aligned address, tagged with the thread number.
- R3: A request sampled at one rising edge produces its response (resp_valid, with resp_tid equal to the request's thread) after the following rising edge, and at no other time.
- R4: A refill is two beats on mem_rdata: the first beat carries block bytes 0..15 and the second carries bytes 16..31. Once the second beat is taken, a repeated access hits and returns the 32-bit word at block offset addr[4:2]*4.
- R5: While a thread's refill is outstanding, every access of that thread replays and issues no new memory command.
- R6: A store hit writes byte i of req_wdata (bits 8i+7..8i) wherever req_be[i]=1, keeps the other bytes, and marks the line dirty.
- R7: A miss that displaces a dirty line first issues a write command for the victim's block address. That write carries the stored line in two beats, bytes 0..15 first, and the read command for the new block follows it.
- R8: A miss that displaces a clean line issues only the read command.
- R9: Threads are isolated: the same address used by two threads occupies two lines, and refilling one thread's copy leaves the other thread's copy hitting.
- R10: While one thread is pending, hits of other threads still hit and return data.
- R11: With 8 lines per thread, the line index is addr[7:5] and the tag is addr[31:8]. Two addresses of one thread that differ only above bit 7 conflict.
- R12: A memory command that is not accepted (mem_req_ready=0) stays presented, unchanged, until accepted.
- R13: A store hit by one thread and the final refill beat of another thread can land in the same cycle, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_tid | input | 3 | Thread number of the access |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables for a store |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Access completed |
| resp_replay | output | 1 | Access must be issued again later |
| resp_tid | output | 3 | Thread number of the response |
| resp_rdata | output | 32 | Load data on a hit |
| mem_req_valid | output | 1 | Memory command present |
| mem_req_ready | input | 1 | Memory accepts the command or write beat |
| mem_req_we | output | 1 | 1 = writeback beat, 0 = block read |
| mem_req_addr | output | 32 | 32-byte-aligned block address |
| mem_req_tid | output | 3 | Thread owning the command |
| mem_req_wdata | output | 128 | Writeback beat data |
| mem_rvalid | input | 1 | Refill beat present |
| mem_rtid | input | 3 | Thread the refill belongs to |
| mem_rdata | input | 128 | Refill beat data |

## Verification
The two functions that can coincide are a store hit merging bytes into one thread's line and the second refill beat installing a block for another thread. Both write the data array, the valid bits and the dirty bits at the same edge. The bench provokes this by driving the store request in the same cycle as the first refill beat, so the store merge and the refill completion are taken at the same edge. The case is judged by later loads: the storing thread must read back its merged word, and the refilled thread must hit with the memory contents.

// File: rtl/pt_dcache.sv
`timescale 1ns/100ps
module pt_dcache #(
  parameter int THREADS = 8,
  parameter int LINES   = 8,
  parameter int FDEPTH  = 8,
  parameter int AW      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [$clog2(THREADS)-1:0]   req_tid,
  input  logic                         req_we,
  input  logic [AW-1:0]                req_addr,
  input  logic [3:0]                   req_be,
  input  logic [31:0]                  req_wdata,
  output logic                         resp_valid,
  output logic                         resp_hit,
  output logic                         resp_replay,
  output logic [$clog2(THREADS)-1:0]   resp_tid,
  output logic [31:0]                  resp_rdata,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_we,
  output logic [AW-1:0]                mem_req_addr,
  output logic [$clog2(THREADS)-1:0]   mem_req_tid,
  output logic [127:0]                 mem_req_wdata,
  input  logic                         mem_rvalid,
  input  logic [$clog2(THREADS)-1:0]   mem_rtid,
  input  logic [127:0]                 mem_rdata
);
  localparam int TW   = $clog2(THREADS);
  localparam int LB   = $clog2(LINES);
  localparam int SB   = TW + LB;
  localparam int SETS = THREADS * LINES;
  localparam int TGW  = AW - 5 - LB;
  localparam int FPW  = $clog2(FDEPTH);

  logic          s1_v, s1_we;
  logic [TW-1:0] s1_tid;
  logic [AW-1:0] s1_addr;
  logic [3:0]    s1_be;
  logic [31:0]   s1_wd;

  logic [255:0]   dat  [SETS];
  logic [TGW-1:0] tagm [SETS];
  logic [SETS-1:0] vld, drt;

  logic [THREADS-1:0] pend;
  logic [SB-1:0]  pset [THREADS];
  logic [TGW-1:0] ptag [THREADS];

  logic           fq_we  [FDEPTH];
  logic [SB-1:0]  fq_set [FDEPTH];
  logic [TGW-1:0] fq_tag [FDEPTH];
  logic [FPW-1:0] wp, rp;
  logic [FPW:0]   cnt;
  logic           wbeat, rbeat;
  logic [127:0]   rlo;

  wire [SB-1:0]  set1  = {s1_tid, s1_addr[5+LB-1:5]};
  wire [TGW-1:0] tag1  = s1_addr[AW-1:5+LB];
  wire [255:0]   line1 = dat[set1];
  wire [7:0]     wsel  = {s1_addr[4:2], 5'b0};
  wire [31:0]    word1 = line1[wsel +: 32];
  wire hit1 = s1_v && vld[set1] && (tagm[set1] == tag1) && !pend[s1_tid];
  wire vict = vld[set1] && drt[set1];
  wire [1:0] need = vict ? 2'd2 : 2'd1;
  wire miss_go = s1_v && !hit1 && !pend[s1_tid] && (int'(cnt) + int'(need) <= FDEPTH);
  wire [1:0] push = miss_go ? need : 2'd0;

  logic [31:0] mw;
  always_comb
    for (int i = 0; i < 4; i++)
      mw[8*i +: 8] = s1_be[i] ? s1_wd[8*i +: 8] : word1[8*i +: 8];

  wire [SB-1:0]  hset  = fq_set[rp];
  wire [255:0]   hline = dat[hset];
  assign mem_req_valid = cnt != '0;
  assign mem_req_we    = fq_we[rp];
  assign mem_req_addr  = {fq_tag[rp], hset[LB-1:0], 5'b0};
  assign mem_req_tid   = hset[SB-1:LB];
  assign mem_req_wdata = wbeat ? hline[255:128] : hline[127:0];
  wire fire  = mem_req_valid && mem_req_ready;
  wire pop   = fire && (!mem_req_we || wbeat);
  wire rdone = mem_rvalid && rbeat;
  wire [SB-1:0] rset = pset[mem_rtid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; resp_valid <= 1'b0; resp_hit <= 1'b0; resp_replay <= 1'b0;
      vld <= '0; drt <= '0; pend <= '0;
      wp <= '0; rp <= '0; cnt <= '0; wbeat <= 1'b0; rbeat <= 1'b0;
    end else begin
      s1_v        <= req_valid;
      resp_valid  <= s1_v;
      resp_hit    <= hit1;
      resp_replay <= s1_v && !hit1;
      if (hit1 && s1_we) drt[set1] <= 1'b1;
      if (miss_go) pend[s1_tid] <= 1'b1;
      if (mem_rvalid) rbeat <= !rbeat;
      if (rdone) begin
        vld[rset] <= 1'b1;
        drt[rset] <= 1'b0;
        pend[mem_rtid] <= 1'b0;
      end
      if (fire && mem_req_we) wbeat <= !wbeat;
      wp  <= wp + FPW'(push);
      rp  <= rp + FPW'(pop);
      cnt <= cnt + (FPW+1)'(push) - (FPW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    s1_tid <= req_tid; s1_we <= req_we; s1_addr <= req_addr;
    s1_be  <= req_be;  s1_wd <= req_wdata;
    resp_tid   <= s1_tid;
    resp_rdata <= word1;
    if (hit1 && s1_we) dat[set1][wsel +: 32] <= mw;
    if (mem_rvalid && !rbeat) rlo <= mem_rdata;
    if (rdone) begin
      dat[rset]  <= {mem_rdata, rlo};
      tagm[rset] <= ptag[mem_rtid];
    end
    if (miss_go) begin
      pset[s1_tid] <= set1;
      ptag[s1_tid] <= tag1;
      if (vict) begin
        fq_we[wp] <= 1'b1; fq_set[wp] <= set1; fq_tag[wp] <= tagm[set1];
        fq_we[wp + 1'b1] <= 1'b0; fq_set[wp + 1'b1] <= set1; fq_tag[wp + 1'b1] <= tag1;
      end else begin
        fq_we[wp] <= 1'b0; fq_set[wp] <= set1; fq_tag[wp] <= tag1;
      end
    end
  end
endmodule

// File: rtl/pt_dcache_chk.sv
`timescale 1ns/100ps
module pt_dcache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_replay,
  input logic mem_req_valid,
  input logic mem_req_ready,
  input logic mem_req_we
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !resp_valid && !mem_req_valid);
  a_r2_hit_xor_replay: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit ^ resp_replay));
  a_r3_resp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 resp_valid);
  a_r3_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ##1 !resp_valid);
  a_r12_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we));
endmodule

bind pt_dcache pt_dcache_chk chk_i (.*);

// File: tb/pt_dcache_tb_top.sv
`timescale 1ns/100ps
module pt_dcache_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_we = 0;
  logic [2:0] req_tid = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_be = 0;
  logic resp_valid, resp_hit, resp_replay;
  logic [2:0] resp_tid;
  logic [31:0] resp_rdata;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1;
  logic [31:0] mem_req_addr;
  logic [2:0] mem_req_tid;
  logic [127:0] mem_req_wdata;
  logic mem_rvalid = 0;
  logic [2:0] mem_rtid = 0;
  logic [127:0] mem_rdata = 0;

  pt_dcache dut_i (.*);

  int errs = 0, checks = 0;
  logic r_v, r_hit, r_rep, pre_v;
  logic [31:0] r_dat;
  logic [2:0] r_tid;

  logic lg_we [256];
  logic [31:0] lg_addr [256];
  logic [127:0] lg_dat [256];
  logic [2:0] lg_tid [256];
  int nlog = 0, rdp = 0;
  logic whalf = 0;
  logic [31:0] wmem [int unsigned];

  function automatic logic [31:0] base(logic [31:0] a);
    return (a * 32'h9E37) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mword(logic [31:0] a);
    return wmem.exists(a) ? wmem[a] : base(a);
  endfunction
  function automatic logic [127:0] quad(logic [31:0] a);
    return {mword(a + 12), mword(a + 8), mword(a + 4), mword(a)};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      lg_we[nlog] = mem_req_we; lg_addr[nlog] = mem_req_addr;
      lg_dat[nlog] = mem_req_wdata; lg_tid[nlog] = mem_req_tid;
      if (mem_req_we) begin
        for (int k = 0; k < 4; k++)
          wmem[mem_req_addr + (whalf ? 16 : 0) + 4*k] = mem_req_wdata[32*k +: 32];
        whalf = !whalf;
      end
      nlog++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc(input logic [2:0] t, input logic we, input logic [31:0] a,
                     input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_tid = t; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; pre_v = resp_valid;
    @(negedge clk);
    r_v = resp_valid; r_hit = resp_hit; r_rep = resp_replay; r_dat = resp_rdata; r_tid = resp_tid;
  endtask

  task automatic refill(input bit st, input logic [2:0] t, input logic [31:0] a,
                        input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] ra;
    while (rdp < nlog && lg_we[rdp]) rdp++;
    ra = lg_addr[rdp];
    @(negedge clk);
    mem_rvalid = 1; mem_rtid = lg_tid[rdp]; mem_rdata = quad(ra);
    if (st) begin
      req_valid = 1; req_tid = t; req_we = 1; req_addr = a; req_be = be; req_wdata = wd;
    end
    rdp++;
    @(negedge clk);
    mem_rdata = quad(ra + 16); req_valid = 0;
    @(negedge clk);
    mem_rvalid = 0;
    r_v = resp_valid; r_hit = resp_hit;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int n0;
    logic [31:0] merged, a1;
    idle(3); rst_n = 1; idle(2);
    chk(!resp_valid && !mem_req_valid, "R1 idle after reset", {resp_valid, mem_req_valid}, 0);

    acc(0, 0, 32'h1000_0044, 0, 0);
    chk(r_v && r_rep && !r_hit, "R1 R2 first access replays", {r_v, r_hit, r_rep}, 3'b101);
    chk(!pre_v && r_tid == 0, "R3 response one edge after capture", {pre_v, r_tid}, 0);
    idle(3);
    chk(nlog == 1 && !lg_we[0] && lg_addr[0] == 32'h1000_0040 && lg_tid[0] == 0,
        "R2 read command", {lg_we[0], lg_addr[0]}, 32'h1000_0040);
    n0 = nlog;
    acc(0, 0, 32'h1000_0880, 0, 0); idle(3);
    chk(r_rep && nlog == n0, "R5 pending thread replays quietly", nlog, n0);

    refill(0, 0, 0, 0, 0);
    acc(0, 0, 32'h1000_0044, 0, 0);
    chk(r_hit && r_dat == base(32'h1000_0044), "R4 low beat word", r_dat, base(32'h1000_0044));
    acc(0, 0, 32'h1000_005C, 0, 0);
    chk(r_hit && r_dat == base(32'h1000_005C), "R4 high beat word", r_dat, base(32'h1000_005C));

    acc(1, 0, 32'h1000_0044, 0, 0);
    chk(r_rep, "R9 other thread misses same address", r_rep, 1);
    acc(0, 0, 32'h1000_0048, 0, 0);
    chk(r_hit && r_dat == base(32'h1000_0048) && r_tid == 0, "R10 hit while other pending", r_dat, base(32'h1000_0048));
    idle(2); refill(0, 0, 0, 0, 0);
    acc(0, 0, 32'h1000_0040, 0, 0);
    chk(r_hit, "R9 thread 0 copy kept", r_hit, 1);
    acc(1, 0, 32'h1000_0044, 0, 0);
    chk(r_hit && r_tid == 1, "R9 thread 1 copy hits", r_hit, 1);

    merged = (base(32'h1000_0048) & 32'hFF00FF00) | (32'hDEADBEEF & 32'h00FF00FF);
    acc(0, 1, 32'h1000_0048, 4'b0101, 32'hDEADBEEF);
    chk(r_hit, "R6 store hit", r_hit, 1);
    acc(0, 0, 32'h1000_0048, 0, 0);
    chk(r_dat == merged, "R6 merged bytes", r_dat, merged);

    n0 = nlog;
    acc(0, 0, 32'h2000_0048, 0, 0);
    chk(r_rep, "R11 conflicting tag misses", r_rep, 1);
    idle(5);
    chk(nlog == n0 + 3, "R7 three memory transfers", nlog, n0 + 3);
    chk(lg_we[n0] && lg_addr[n0] == 32'h1000_0040 &&
        lg_dat[n0] == {base(32'h1000_004C), merged, base(32'h1000_0044), base(32'h1000_0040)},
        "R7 victim low beat", lg_dat[n0], {base(32'h1000_004C), merged, base(32'h1000_0044), base(32'h1000_0040)});
    chk(lg_we[n0+1] && lg_dat[n0+1] == {base(32'h1000_005C), base(32'h1000_0058), base(32'h1000_0054), base(32'h1000_0050)},
        "R7 victim high beat", lg_dat[n0+1], 0);
    chk(!lg_we[n0+2] && lg_addr[n0+2] == 32'h2000_0040, "R7 read after writeback", lg_addr[n0+2], 32'h2000_0040);
    refill(0, 0, 0, 0, 0);
    acc(0, 0, 32'h2000_0048, 0, 0);
    chk(r_hit && r_dat == base(32'h2000_0048), "R11 new tag hits", r_dat, base(32'h2000_0048));
    n0 = nlog;
    acc(0, 0, 32'h1000_0048, 0, 0); idle(4);
    chk(r_rep && nlog == n0 + 1 && !lg_we[n0], "R8 clean victim read only", nlog, n0 + 1);
    refill(0, 0, 0, 0, 0);
    acc(0, 0, 32'h1000_0048, 0, 0);
    chk(r_hit && r_dat == merged, "R7 written data round trip", r_dat, merged);

    mem_req_ready = 0; n0 = nlog;
    acc(2, 0, 32'h3000_00A0, 0, 0); idle(2);
    a1 = mem_req_addr;
    idle(3);
    chk(mem_req_valid && mem_req_addr == a1 && a1 == 32'h3000_00A0 && nlog == n0,
        "R12 command held", mem_req_addr, 32'h3000_00A0);
    mem_req_ready = 1; idle(3);
    chk(nlog == n0 + 1, "R12 command taken", nlog, n0 + 1);
    refill(0, 0, 0, 0, 0);

    acc(3, 0, 32'h4000_00C4, 0, 0); idle(3);
    refill(1, 2, 32'h3000_00A4, 4'b1111, 32'h1234_5678);
    chk(r_v && r_hit, "R13 store hit during refill", r_hit, 1);
    acc(2, 0, 32'h3000_00A4, 0, 0);
    chk(r_hit && r_dat == 32'h1234_5678, "R13 store landed", r_dat, 32'h1234_5678);
    acc(3, 0, 32'h4000_00C4, 0, 0);
    chk(r_hit && r_dat == base(32'h4000_00C4), "R13 refill landed", r_dat, base(32'h4000_00C4));

    for (int t = 0; t < 8; t++)
      for (int l = 0; l < 8; l++) begin
        logic [31:0] a;
        a = 32'h5000_0000 + t * 32'h100 + l * 32 + ((t + l) % 8) * 4;
        acc(t[2:0], 0, a, 0, 0);
        chk(r_rep, "R11 sweep miss", r_rep, 1);
        idle(4);
        refill(0, 0, 0, 0, 0);
        acc(t[2:0], 0, a, 0, 0);
        chk(r_hit && r_dat == mword(a) && r_tid == t[2:0], "R4 sweep hit data", r_dat, mword(a));
      end
    summary();
  end
endmodule